// File: doc/BRIEF.md
# RV64 Load/Store Access Formatter

This is a purely combinational unit that sits between instruction decode and a 64-bit data memory port. It takes the instruction word, the base register value and the store source register value. It recognises the base load and store major opcodes and forms the effective address. For a store it produces write data placed in the right byte lanes, together with an 8-bit byte-enable. For a load it selects the right lanes from the aligned 64-bit word that memory returns, then sign- or zero-extends them into a 64-bit result.

All four access sizes are handled: byte, halfword, word and doubleword. The loads come in signed and unsigned forms, including the unsigned word load that zero-extends into the full register. Any access whose address is not a multiple of its size is flagged and produces no side effect. Width codes that do not exist are flagged as illegal. Timing, bus handshakes and trap handling belong to the surrounding pipeline.

Top module: `rv64_ls_fmt`

## Requirements
- R1: Opcode bits[6:0]=0000011 asserts is_load_o and 0100011 asserts is_store_o. Any other opcode asserts neither, and then be_o, ldata_o, misaligned_o and illegal_o are all zero.
- R2: For a load, addr_o equals base_i plus the sign-extended 12-bit offset taken from instr_i[31:20], modulo 2^64.
- R3: For a store, addr_o equals base_i plus the sign extension of the 12-bit offset {instr_i[31:25], instr_i[11:7]}, where bits[31:25] are offset bits 11..5.
- R4: A load with width code (instr_i[14:12]) 011 returns all 64 bits of rdata_i unchanged when addr_o[2:0]=0.
- R5: A load with code 110 returns the 32-bit word at byte lane addr_o[2:0], zero-extended to 64 bits.
- R6: Load codes 000, 001 and 010 return the byte, halfword or word starting at byte lane addr_o[2:0] of rdata_i (little-endian), sign-extended to 64 bits.
- R7: Load codes 100 and 101 return the byte or halfword starting at lane addr_o[2:0], zero-extended.
- R8: Store codes 000, 001, 010 and 011 write 1, 2, 4 or 8 bytes. For a legal, aligned store, be_o has exactly those lanes set, starting at lane addr_o[2:0].
- R9: For a store, wdata_o equals data_i shifted left by 8*addr_o[2:0] bits, so that byte k of the source lands in lane addr_o[2:0]+k.
- R10: A legal load or store whose addr_o[2:0] is not a multiple of its size in bytes raises misaligned_o. In that case be_o is zero and ldata_o is zero.
- R11: Load code 111 and store codes 100 through 111 raise illegal_o and keep misaligned_o low, with be_o and ldata_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| base_i | input | 64 | Base register value |
| data_i | input | 64 | Store source register value |
| rdata_i | input | 64 | Aligned 64-bit word read from memory at addr_o with bits[2:0] cleared |
| addr_o | output | 64 | Effective byte address |
| is_load_o | output | 1 | Instruction is a load |
| is_store_o | output | 1 | Instruction is a store |
| wdata_o | output | 64 | Lane-aligned store data |
| be_o | output | 8 | Store byte enables, one per lane |
| ldata_o | output | 64 | Extended load result |
| misaligned_o | output | 1 | Access address not aligned to its size |
| illegal_o | output | 1 | Width code does not exist for this opcode |

## Verification
The bench builds the unit with its defaults: a 64-bit data path (eight byte lanes) and a 12-bit offset. With these, every size/offset pairing is reachable, including a doubleword on lane 0 and a byte on lane 7. Offsets near both ends of the signed 12-bit range are reachable as well, which exercises both the split store offset and the sign extension. The memory image is seeded with bytes whose top bit is set, so a mixed-up signed and unsigned extension changes the upper 56, 48 or 32 bits visibly.

// File: rtl/rv64_ls_pkg.sv
package rv64_ls_pkg;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic        is_load;
    logic        is_store;
    acc_size_e   size;
    logic        zext;
    logic        illegal;
    logic [11:0] offset;
  } ls_dec_t;

endpackage

// File: rtl/rv64_ls_decode.sv
module rv64_ls_decode
  import rv64_ls_pkg::*;
#(
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0] instr_i,
  output ls_dec_t         dec_o
);

  logic [6:0] opc;
  logic [2:0] f3;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];

  always_comb begin
    dec_o          = '0;
    dec_o.is_load  = (opc == OPC_LOAD);
    dec_o.is_store = (opc == OPC_STORE);
    dec_o.size     = acc_size_e'(f3[1:0]);
    dec_o.zext     = f3[2];
    // store offset is split around the rs fields
    dec_o.offset   = dec_o.is_store ? {instr_i[31:25], instr_i[11:7]}
                                    : instr_i[31:20];
    dec_o.illegal  = (dec_o.is_load && (f3 == 3'b111)) ||
                     (dec_o.is_store && f3[2]);
  end

endmodule

// File: rtl/rv64_ls_agen.sv
module rv64_ls_agen #(
  parameter int XLEN  = 64,
  parameter int OFF_W = 12
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [XLEN-1:0]  addr_o
);

  logic [XLEN-1:0] off_sext;

  assign off_sext = {{(XLEN-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign addr_o   = base_i + off_sext;

endmodule

// File: rtl/rv64_ls_misalign.sv
module rv64_ls_misalign
  import rv64_ls_pkg::*;
#(
  parameter int OFF_BITS = 3
) (
  input  acc_size_e           size_i,
  input  logic [OFF_BITS-1:0] lo_i,
  output logic                mis_o
);

  logic [OFF_BITS-1:0] need_zero;

  // bit k must be clear when the access spans more than 2^k bytes
  for (genvar k = 0; k < OFF_BITS; k++) begin : g_mask
    assign need_zero[k] = ({1'b0, size_i} > 3'(k));
  end

  assign mis_o = |(lo_i & need_zero);

endmodule

// File: rtl/rv64_ls_store_align.sv
module rv64_ls_store_align
  import rv64_ls_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                        en_i,
  input  acc_size_e                   size_i,
  input  logic [$clog2(XLEN/8)-1:0]   lo_i,
  input  logic [XLEN-1:0]             data_i,
  output logic [XLEN-1:0]             wdata_o,
  output logic [XLEN/8-1:0]           be_o
);

  localparam int NB       = XLEN / 8;
  localparam int OFF_BITS = $clog2(NB);

  logic [OFF_BITS:0] nbytes;

  assign nbytes  = (OFF_BITS+1)'(1) << size_i;
  assign wdata_o = data_i << {lo_i, 3'b000};

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [OFF_BITS:0] rel;
    assign rel     = (OFF_BITS+1)'(i) - {1'b0, lo_i};
    assign be_o[i] = en_i && !rel[OFF_BITS] && (rel < nbytes);
  end

endmodule

// File: rtl/rv64_ls_load_extract.sv
module rv64_ls_load_extract
  import rv64_ls_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                      en_i,
  input  acc_size_e                 size_i,
  input  logic                      zext_i,
  input  logic [$clog2(XLEN/8)-1:0] lo_i,
  input  logic [XLEN-1:0]           rdata_i,
  output logic [XLEN-1:0]           ldata_o
);

  logic [XLEN-1:0] lane;
  logic [XLEN-1:0] ext;

  assign lane = rdata_i >> {lo_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_B:    ext = {{(XLEN-8){~zext_i & lane[7]}}, lane[7:0]};
      SZ_H:    ext = {{(XLEN-16){~zext_i & lane[15]}}, lane[15:0]};
      SZ_W:    ext = {{(XLEN-32){~zext_i & lane[31]}}, lane[31:0]};
      default: ext = lane;
    endcase
  end

  assign ldata_o = en_i ? ext : '0;

endmodule

// File: rtl/rv64_ls_fmt.sv
module rv64_ls_fmt
  import rv64_ls_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int ILEN  = 32,
  parameter int OFF_W = 12
) (
  input  logic [ILEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   data_i,
  input  logic [XLEN-1:0]   rdata_i,
  output logic [XLEN-1:0]   addr_o,
  output logic              is_load_o,
  output logic              is_store_o,
  output logic [XLEN-1:0]   wdata_o,
  output logic [XLEN/8-1:0] be_o,
  output logic [XLEN-1:0]   ldata_o,
  output logic              misaligned_o,
  output logic              illegal_o
);

  localparam int NB       = XLEN / 8;
  localparam int OFF_BITS = $clog2(NB);

  ls_dec_t             dec;
  logic                mis_raw;
  logic                legal_mem;
  logic                st_en;
  logic                ld_en;
  logic [OFF_BITS-1:0] lo;

  rv64_ls_decode #(.ILEN(ILEN)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  rv64_ls_agen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agen (
    .base_i   (base_i),
    .offset_i (dec.offset),
    .addr_o   (addr_o)
  );

  assign lo = addr_o[OFF_BITS-1:0];

  rv64_ls_misalign #(.OFF_BITS(OFF_BITS)) u_mis (
    .size_i (dec.size),
    .lo_i   (lo),
    .mis_o  (mis_raw)
  );

  assign legal_mem = (dec.is_load || dec.is_store) && !dec.illegal;
  assign st_en     = dec.is_store && legal_mem && !mis_raw;
  assign ld_en     = dec.is_load  && legal_mem && !mis_raw;

  rv64_ls_store_align #(.XLEN(XLEN)) u_st (
    .en_i    (st_en),
    .size_i  (dec.size),
    .lo_i    (lo),
    .data_i  (data_i),
    .wdata_o (wdata_o),
    .be_o    (be_o)
  );

  rv64_ls_load_extract #(.XLEN(XLEN)) u_ld (
    .en_i    (ld_en),
    .size_i  (dec.size),
    .zext_i  (dec.zext),
    .lo_i    (lo),
    .rdata_i (rdata_i),
    .ldata_o (ldata_o)
  );

  assign is_load_o    = dec.is_load;
  assign is_store_o   = dec.is_store;
  assign misaligned_o = legal_mem && mis_raw;
  assign illegal_o    = dec.illegal;

endmodule

// File: rtl/rv64_ls_fmt_chk.sv
module rv64_ls_fmt_chk #(
  parameter int XLEN = 64
) (
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] base_i,
  input logic [XLEN-1:0] addr_o,
  input logic            is_load_o,
  input logic            is_store_o,
  input logic [XLEN/8-1:0] be_o,
  input logic [XLEN-1:0] ldata_o,
  input logic            misaligned_o,
  input logic            illegal_o
);

  logic signed [XLEN-1:0] delta;
  assign delta = $signed(addr_o - base_i);

  always_comb begin
    if (!$isunknown({instr_i, base_i})) begin
      a_r1_kind_exclusive: assert (!(is_load_o && is_store_o));
      a_r1_flags_need_mem: assert (!(misaligned_o || illegal_o) || is_load_o || is_store_o);
      a_r8_be_shape: assert ($countones(be_o) inside {0, 1, 2, 4, 8});
      a_r10_be_gated: assert (be_o == '0 || (is_store_o && !misaligned_o && !illegal_o));
      a_r10_ldata_quiet: assert (ldata_o == '0 || (is_load_o && !misaligned_o && !illegal_o));
      a_r11_flags_exclusive: assert (!(misaligned_o && illegal_o));
      a_r2_addr_window: assert (delta >= -2048 && delta <= 2047);
    end
  end

endmodule

bind rv64_ls_fmt rv64_ls_fmt_chk #(.XLEN(XLEN)) chk_i (
  .instr_i      (instr_i),
  .base_i       (base_i),
  .addr_o       (addr_o),
  .is_load_o    (is_load_o),
  .is_store_o   (is_store_o),
  .be_o         (be_o),
  .ldata_o      (ldata_o),
  .misaligned_o (misaligned_o),
  .illegal_o    (illegal_o)
);

// File: tb/rv64_ls_fmt_tb_top.sv
`timescale 1ns/1ps
module rv64_ls_fmt_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr;
  logic [63:0] base, sdata, rdata;
  logic [63:0] addr, wdata, ldata;
  logic [7:0]  be;
  logic        is_ld, is_st, mis, ill;

  logic [7:0]  mem [256];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;  // 50 MHz

  rv64_ls_fmt dut_i (
    .instr_i      (instr),
    .base_i       (base),
    .data_i       (sdata),
    .rdata_i      (rdata),
    .addr_o       (addr),
    .is_load_o    (is_ld),
    .is_store_o   (is_st),
    .wdata_o      (wdata),
    .be_o         (be),
    .ldata_o      (ldata),
    .misaligned_o (mis),
    .illegal_o    (ill)
  );

  // aligned doubleword read from the byte memory model
  always_comb begin
    for (int j = 0; j < 8; j++) rdata[8*j +: 8] = mem[{addr[7:3], 3'(j)}];
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_load(input logic [2:0] f3, input logic [11:0] off);
    return {off, 5'd6, f3, 5'd5, 7'b0000011};
  endfunction

  function automatic logic [31:0] mk_store(input logic [2:0] f3, input logic [11:0] off);
    return {off[11:5], 5'd7, 5'd6, f3, off[4:0], 7'b0100011};
  endfunction

  function automatic logic [63:0] sx12(input logic [11:0] v);
    return {{52{v[11]}}, v};
  endfunction

  function automatic logic exp_mis(input logic [63:0] a, input logic [1:0] sz);
    int n = 1 << sz;
    return (a[2:0] % n) != 0;
  endfunction

  function automatic logic [63:0] exp_load(input logic [63:0] a, input logic [2:0] f3);
    int n = 1 << f3[1:0];
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v |= 64'(mem[8'(a + 64'(i))]) << (8 * i);
    if (!f3[2] && n < 8 && v[8*n-1]) v |= ~((64'd1 << (8 * n)) - 64'd1);
    return v;
  endfunction

  task automatic do_load(input logic [2:0] f3, input logic [63:0] b, input logic [11:0] off);
    logic [63:0] ea;
    logic ill_e, mis_e;
    @(posedge clk);
    instr = mk_load(f3, off); base = b; sdata = $urandom();
    @(negedge clk);
    ea    = b + sx12(off);
    ill_e = (f3 == 3'b111);
    mis_e = !ill_e && exp_mis(ea, f3[1:0]);
    chk("R2 load address", addr, ea);
    chk("R1 load kind", {62'd0, is_ld, is_st}, 64'd2);
    chk("R11 illegal flag", 64'(ill), 64'(ill_e));
    chk("R10 misaligned flag", 64'(mis), 64'(mis_e));
    if (ill_e || mis_e) chk("R10 R11 load quiet", ldata, 64'd0);
    else if (f3 == 3'b011) chk("R4 doubleword load", ldata, exp_load(ea, f3));
    else if (f3 == 3'b110) chk("R5 unsigned word load", ldata, exp_load(ea, f3));
    else if (f3[2])        chk("R7 unsigned narrow load", ldata, exp_load(ea, f3));
    else                   chk("R6 signed load", ldata, exp_load(ea, f3));
    chk("R10 no write on load", 64'(be), 64'd0);
  endtask

  task automatic do_store(input logic [2:0] f3, input logic [63:0] b, input logic [11:0] off,
                          input logic [63:0] src);
    logic [63:0] ea, img_e, img_a;
    logic [7:0]  be_e;
    logic ill_e, mis_e;
    int n;
    @(posedge clk);
    instr = mk_store(f3, off); base = b; sdata = src;
    @(negedge clk);
    ea    = b + sx12(off);
    ill_e = f3[2];
    mis_e = !ill_e && exp_mis(ea, f3[1:0]);
    n     = 1 << f3[1:0];
    be_e  = '0;
    for (int j = 0; j < 8; j++) begin
      img_e[8*j +: 8] = mem[{ea[7:3], 3'(j)}];
      img_a[8*j +: 8] = mem[{ea[7:3], 3'(j)}];
    end
    if (!ill_e && !mis_e)
      for (int i = 0; i < n; i++) begin
        be_e[ea[2:0] + 3'(i)] = 1'b1;
        img_e[8*(ea[2:0] + 3'(i)) +: 8] = src[8*i +: 8];
      end
    for (int j = 0; j < 8; j++) if (be[j]) img_a[8*j +: 8] = wdata[8*j +: 8];
    chk("R3 store address", addr, ea);
    chk("R1 store kind", {62'd0, is_ld, is_st}, 64'd1);
    chk("R11 illegal flag", 64'(ill), 64'(ill_e));
    chk("R10 misaligned flag", 64'(mis), 64'(mis_e));
    chk("R8 byte enables", 64'(be), 64'(be_e));
    chk("R9 store data lanes", wdata, src << (8 * ea[2:0]));
    chk("R8 R9 memory image", img_a, img_e);
    chk("R1 no load data on store", ldata, 64'd0);
    for (int j = 0; j < 8; j++) mem[{ea[7:3], 3'(j)}] = img_a[8*j +: 8];
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'h80 | 8'($urandom());
    instr = '0; base = '0; sdata = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // reset state: null instruction
    chk("R1 reset kind", {62'd0, is_ld, is_st}, 64'd0);
    chk("R1 reset be", 64'(be), 64'd0);
    chk("R1 reset ldata", ldata, 64'd0);
    chk("R1 reset flags", {62'd0, mis, ill}, 64'd0);
    rst_ni = 1'b1;
    // non-memory opcode with a width code that would be illegal
    @(posedge clk);
    instr = {12'hfff, 5'd6, 3'b111, 5'd5, 7'b0010011}; base = 64'h8000_0000_0000_0003;
    @(negedge clk);
    chk("R1 other opcode kind", {62'd0, is_ld, is_st}, 64'd0);
    chk("R1 other opcode flags", {62'd0, mis, ill}, 64'd0);
    chk("R1 other opcode be", 64'(be), 64'd0);
    chk("R1 other opcode ldata", ldata, 64'd0);
    // every code at every lane, negative offsets, top-bit data
    for (int f = 0; f < 8; f++)
      for (int o = 0; o < 8; o++) begin
        do_load(3'(f), 64'h8000_0000_0000_0040, 12'(o - 16));
        do_store(3'(f), 64'hffff_ffff_ffff_ff80, 12'(o + 8), 64'hf1e2_d3c4_b5a6_9788);
      end
    // offset extremes
    do_load(3'b011, 64'h0000_0000_0000_1000, 12'h800);
    do_load(3'b110, 64'h0000_0000_0000_1000, 12'h7fc);
    do_store(3'b011, 64'h0000_0000_0000_1000, 12'h800, 64'h8000_0000_0000_0001);
    do_store(3'b010, 64'h0000_0000_0000_1000, 12'h7fc, 64'hffff_ffff_8765_4321);
    // constrained random mix
    for (int k = 0; k < 1500; k++) begin
      logic [63:0] b = {$urandom(), $urandom()};
      logic [11:0] of = 12'($urandom());
      logic [2:0]  f3 = 3'($urandom());
      if ($urandom_range(0, 1) == 0) do_load(f3, b, of);
      else do_store(f3, b, of, {$urandom(), $urandom()} | 64'h8000_0000_8000_8080);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule